// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block gathers sixteen interrupt request lines into one interrupt request to the processor. Two eight-line priority units are chained: the upper unit serves lines 8 to 15, and its request output takes the place of line 2 in the lower unit, which serves lines 0 to 7 and drives the processor request. Each line is sensed on its rising edge only. A latched request waits as pending until the processor acknowledges it, and then it moves into service until an end-of-service strobe retires it.

The processor sees `int_req` and answers with a one-cycle `int_ack`. One cycle later the block returns the winning line number on `vec_num` with `vec_valid` high. Nesting follows the chain: a pending line reaches the processor only when it outranks every line now in service. Because of this the effective order is 0, 1, 8 through 15, 3 through 7. A global enable that the processor sets and clears gates the request. A per-line mask hides lines without dropping edges that are already latched. A device wired to the old line-2 pin is served as line 9.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset `int_req` and `vec_valid` are 0, nothing is pending or in service, every mask bit is clear and the global enable is off.
- R2: A request is latched only on a low-to-high transition of its line. A line that stays high yields exactly one request, and a falling edge yields none.
- R3: When several lines are pending, the acknowledged vectors come out in the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R4: An `int_ack` sampled while `int_req` is high makes `vec_valid` high for exactly the next cycle, with `vec_num` holding the winning line number (4 bits, binary). That line moves from pending into service. An `int_ack` while `int_req` is low has no effect.
- R5: `int_req` is high only when the best unmasked pending line outranks every line in service. While any line 8 to 15 is in service, lines 3 to 15 are held off and lines 0 and 1 can still preempt.
- R6: `eoi` retires the highest-priority line in service. Retiring a line from 8 to 15 also frees the cascade slot, so lines 3 to 7 and the other upper lines can be requested again.
- R7: A rising edge on a line that is in service is lost: it leaves nothing pending after that line is retired.
- R8: A rising edge on `irq_in[2]` is served as line 9. Vector 2 is never reported.
- R9: `gie_set` turns the global enable on and `gie_clr` turns it off, and `gie_clr` wins when both are high. While the enable is off `int_req` is 0 and acknowledges are ignored, but pending lines are kept.
- R10: `mask_wr` loads `mask_data`, where bit n hides line n and bit 2 has no effect. A hidden line still latches its edge and is requested once its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Interrupt request lines; bit 2 is the old pin and is served as line 9 |
| gie_set | input | 1 | Turn the global enable on |
| gie_clr | input | 1 | Turn the global enable off (wins over set) |
| mask_wr | input | 1 | Load the mask register from mask_data |
| mask_data | input | 16 | Mask value, bit n hides line n |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| eoi | input | 1 | End-of-service strobe |
| vec_valid | output | 1 | Vector is valid, one cycle after an accepted acknowledge |
| vec_num | output | 4 | Number of the acknowledged line |

## Verification
Some properties are checked on every cycle. A held line never re-fires its edge detector. An accepted acknowledge always puts the winning line into service. A line is never pending and in service at once. Any upper line in service forces the cascade slot into service. A vector never comes out without an accepted acknowledge, and it is never 2. Other behaviour shows only in the bench scenarios: the full fifteen-step cascade order, preemption by lines 0 and 1 over an upper line in service, the loss of a repeated edge, release after masking, and the line-2 remap. These need sequences of edges, acknowledges and end-of-service strobes, and the bench compares them with a line-level model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int UNIT_LINES  = 8;
    localparam int IDX_W       = $clog2(UNIT_LINES);
    localparam int TOTAL_LINES = 2 * UNIT_LINES;
    localparam int VEC_W       = IDX_W + 1;
    localparam int CASC_IDX    = 2;
    localparam int LEGACY_LINE = 2;
    localparam int REMAP_LINE  = 9;

    typedef logic [UNIT_LINES-1:0] lines_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic {GIE_OFF = 1'b0, GIE_ON = 1'b1} gie_e;

    // lowest set index wins (highest priority)
    function automatic pick_t pick_lowest(input lines_t v);
        pick_t p;
        p = '0;
        for (int i = UNIT_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic lines_t idx_onehot(input logic [IDX_W-1:0] i);
        lines_t o;
        o = '0;
        o[i] = 1'b1;
        return o;
    endfunction
endpackage

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    // R2
    held_line_single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_pkg::*;
#(
    parameter bit HAS_CASC = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  lines_t           rise,
    input  logic             casc_req,
    input  lines_t           mask,
    input  logic             take,
    input  logic             done,
    output logic             int_out,
    output logic [IDX_W-1:0] win_idx,
    output lines_t           isr
);
    localparam lines_t CASC_BIT = HAS_CASC ? lines_t'(1 << CASC_IDX) : '0;

    lines_t irr_q, isr_q, req_vec, mask_eff, cand, take_vec, done_vec, rise_eff;
    pick_t  win, top;

    generate
        if (HAS_CASC) begin : g_casc
            // cascade slot is a live level from the chained unit, never masked
            assign req_vec  = (irr_q & ~CASC_BIT) | (CASC_BIT & {UNIT_LINES{casc_req}});
            assign mask_eff = mask & ~CASC_BIT;
        end else begin : g_leaf
            assign req_vec  = irr_q | (CASC_BIT & {UNIT_LINES{casc_req}});
            assign mask_eff = mask;
        end
    endgenerate

    assign rise_eff = rise & ~CASC_BIT;
    assign cand     = req_vec & ~mask_eff;

    always_comb begin
        win      = pick_lowest(cand);
        top      = pick_lowest(isr_q);
        int_out  = win.hit && (!top.hit || (win.idx < top.idx));
        take_vec = take ? idx_onehot(win.idx) : '0;
        done_vec = (done && top.hit) ? idx_onehot(top.idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
        end else begin
            irr_q <= (irr_q | (rise_eff & ~isr_q)) & ~take_vec;
            isr_q <= (isr_q | take_vec) & ~done_vec;
        end
    end

    assign win_idx = win.idx;
    assign isr     = isr_q;

    // R4
    take_needs_int_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> int_out);
    // R4
    take_enters_service_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> isr_q[$past(win_idx)]);
    // R7
    pend_service_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (irr_q & isr_q) == '0);
    // R6
    done_retires_top_chk: assert property (@(posedge clk) disable iff (rst)
        (done && top.hit && !take) |=> !isr_q[$past(top.idx)]);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TOTAL_LINES-1:0] irq_in,
    input  logic                   gie_set,
    input  logic                   gie_clr,
    input  logic                   mask_wr,
    input  logic [TOTAL_LINES-1:0] mask_data,
    output logic                   int_req,
    input  logic                   int_ack,
    input  logic                   eoi,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_num
);
    logic [TOTAL_LINES-1:0] lvl, rise, mask_q;
    gie_e                   gie_q;
    lines_t                 p_isr, s_isr;
    logic                   p_int, s_int, ack_go, casc_win, take_s, done_s;
    logic [IDX_W-1:0]       p_win, s_win;
    pick_t                  p_top;
    logic [VEC_W-1:0]       vec_d;

    // old line-2 pin feeds line 9; line 2 itself is the cascade slot
    always_comb begin
        lvl             = irq_in;
        lvl[REMAP_LINE] = irq_in[REMAP_LINE] | irq_in[LEGACY_LINE];
        lvl[LEGACY_LINE] = 1'b0;
    end

    irq_edge_bank #(.W(TOTAL_LINES)) u_edges (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .rise(rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q  <= GIE_OFF;
            mask_q <= '0;
        end else begin
            if (gie_clr)      gie_q <= GIE_OFF;
            else if (gie_set) gie_q <= GIE_ON;
            if (mask_wr) mask_q <= mask_data;
        end
    end

    always_comb begin
        p_top    = pick_lowest(p_isr);
        int_req  = (gie_q == GIE_ON) && p_int;
        ack_go   = int_ack && int_req;
        casc_win = (p_win == IDX_W'(CASC_IDX));
        take_s   = ack_go && casc_win;
        done_s   = eoi && p_top.hit && (p_top.idx == IDX_W'(CASC_IDX));
        vec_d    = casc_win ? {1'b1, s_win} : {1'b0, p_win};
    end

    irq_prio_unit #(.HAS_CASC(1'b1)) u_primary (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise[UNIT_LINES-1:0]),
        .casc_req(s_int),
        .mask    (mask_q[UNIT_LINES-1:0]),
        .take    (ack_go),
        .done    (eoi),
        .int_out (p_int),
        .win_idx (p_win),
        .isr     (p_isr)
    );

    irq_prio_unit #(.HAS_CASC(1'b0)) u_secondary (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise[TOTAL_LINES-1:UNIT_LINES]),
        .casc_req(1'b0),
        .mask    (mask_q[TOTAL_LINES-1:UNIT_LINES]),
        .take    (take_s),
        .done    (done_s),
        .int_out (s_int),
        .win_idx (s_win),
        .isr     (s_isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_num   <= '0;
        end else begin
            vec_valid <= ack_go;
            if (ack_go) vec_num <= vec_d;
        end
    end

    // R9
    gie_clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        gie_clr |=> !int_req);
    // R4
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(int_ack && int_req));
    // R5
    upper_holds_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (s_isr != '0) |-> p_isr[CASC_IDX]);
    // R8
    no_vector_two_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_num != VEC_W'(LEGACY_LINE)));
endmodule

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_in, mask_data;
    logic        gie_set, gie_clr, mask_wr, int_ack, eoi;
    logic        int_req, vec_valid;
    logic [3:0]  vec_num;

    always #5 clk = ~clk;

    irq_cascade_ctrl i_irq_cascade_ctrl (
        .clk(clk), .rst(rst), .irq_in(irq_in), .gie_set(gie_set), .gie_clr(gie_clr),
        .mask_wr(mask_wr), .mask_data(mask_data), .int_req(int_req), .int_ack(int_ack),
        .eoi(eoi), .vec_valid(vec_valid), .vec_num(vec_num)
    );

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] m_pend = '0, m_isr = '0, m_mask = '0, m_prev = '0, cur = '0;
    logic m_gie = 1'b0;

    function automatic int rank(int l);
        if (l < 2) return l;
        if (l >= 8) return l - 6;
        if (l == 2) return 99;
        return l + 7;
    endfunction

    function automatic int prim_of(int l);
        return (l < 8) ? l : 2;
    endfunction

    function automatic int best_of(logic [15:0] v, logic [15:0] msk);
        int b = -1;
        for (int l = 0; l < 16; l++)
            if (l != 2 && v[l] && !msk[l] && (b < 0 || rank(l) < rank(b))) b = l;
        return b;
    endfunction

    function automatic bit exp_int();
        int b = best_of(m_pend, m_mask);
        int pt = 8;
        for (int l = 0; l < 16; l++)
            if (m_isr[l] && prim_of(l) < pt) pt = prim_of(l);
        return m_gie && (b >= 0) && (prim_of(b) < pt);
    endfunction

    function automatic int ord_at(int k);
        if (k < 2) return k;
        if (k < 10) return k + 6;
        return k - 7;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(logic [15:0] irq, bit ack, bit eo, bit gs, bit gc, bit mw, logic [15:0] md);
        bit go;
        int b, t;
        logic [15:0] lv, rise, np;
        @(negedge clk);
        irq_in = irq; int_ack = ack; eoi = eo; gie_set = gs; gie_clr = gc;
        mask_wr = mw; mask_data = md;
        go = ack && exp_int();
        b = best_of(m_pend, m_mask);
        lv = irq; lv[9] = irq[9] | irq[2]; lv[2] = 1'b0;
        rise = lv & ~m_prev;
        m_prev = lv;
        np = m_pend | (rise & ~m_isr);
        t = eo ? best_of(m_isr, 16'h0) : -1;
        if (go) begin np[b] = 1'b0; m_isr[b] = 1'b1; end
        if (t >= 0) m_isr[t] = 1'b0;
        m_pend = np;
        if (gc) m_gie = 1'b0; else if (gs) m_gie = 1'b1;
        if (mw) m_mask = md;
        @(posedge clk);
        #1;
        chk(int_req == exp_int(), "R5 int_req vs model", int'(int_req), int'(exp_int()));
        chk(vec_valid == go, "R4 vec_valid", int'(vec_valid), int'(go));
        if (go) chk(vec_num == 4'(b), "R3 vec_num vs model", int'(vec_num), b);
    endtask

    task automatic idle();         step(cur, 0, 0, 0, 0, 0, 16'h0); endtask
    task automatic do_ack();       step(cur, 1, 0, 0, 0, 0, 16'h0); endtask
    task automatic do_eoi();       step(cur, 0, 1, 0, 0, 0, 16'h0); endtask
    task automatic do_mask(logic [15:0] m); step(cur, 0, 0, 0, 0, 1, m); endtask

    task automatic ack_expect(int line, string tag);
        do_ack();
        chk(vec_valid && vec_num == 4'(line), tag, int'(vec_num), line);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd20240611);
        rst = 1'b1; irq_in = '0; mask_data = '0;
        gie_set = 0; gie_clr = 0; mask_wr = 0; int_ack = 0; eoi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(int_req == 1'b0, "R1 int_req after reset", int'(int_req), 0);
        chk(vec_valid == 1'b0, "R1 vec_valid after reset", int'(vec_valid), 0);
        // enable off after reset: a raised line must not request
        cur = 16'h0001; idle();
        chk(int_req == 1'b0, "R1 enable off after reset", int'(int_req), 0);
        step(cur, 0, 0, 1, 0, 0, 16'h0);
        chk(int_req == 1'b1, "R9 set enables pending line", int'(int_req), 1);
        ack_expect(0, "R4 ack returns line 0");
        do_eoi();
        cur = 16'h0; idle();

        // R4: acknowledge with nothing requested is ignored
        do_ack();
        chk(vec_valid == 1'b0, "R4 ack without request", int'(vec_valid), 0);

        // R3: all lines at once, cascade order
        cur = 16'hFFFB; idle();
        for (int k = 0; k < 15; k++) begin
            ack_expect(ord_at(k), "R3 cascade order");
            do_eoi();
        end
        chk(int_req == 1'b0, "R2 held lines give no second request", int'(int_req), 0);
        cur = 16'h0; idle();
        chk(int_req == 1'b0, "R2 falling edges give nothing", int'(int_req), 0);

        // R8: old line-2 pin
        cur = 16'h0004; idle();
        ack_expect(9, "R8 line-2 pin served as 9");
        do_eoi(); cur = 16'h0; idle();

        // R7: repeated edge while in service is lost
        cur = 16'h0020; idle();
        ack_expect(5, "R7 first edge of line 5");
        cur = 16'h0; idle();
        cur = 16'h0020; idle();
        do_eoi();
        chk(int_req == 1'b0, "R7 second edge lost", int'(int_req), 0);
        cur = 16'h0; idle();

        // R5: nesting inside the lower unit
        cur = 16'h0010; idle();
        ack_expect(4, "R5 line 4 in service");
        cur = 16'h0050; idle();
        chk(int_req == 1'b0, "R5 line 6 held off by 4", int'(int_req), 0);
        cur = 16'h0052; idle();
        chk(int_req == 1'b1, "R5 line 1 preempts 4", int'(int_req), 1);
        ack_expect(1, "R5 nested vector 1");
        do_eoi();
        chk(int_req == 1'b0, "R6 retire 1 keeps 4 blocking", int'(int_req), 0);
        do_eoi();
        ack_expect(6, "R6 line 6 after retiring 4");
        do_eoi(); cur = 16'h0; idle();

        // R5/R6: nesting through the cascade slot
        cur = 16'h0400; idle();
        ack_expect(10, "R5 line 10 in service");
        cur = 16'h1408; idle();
        chk(int_req == 1'b0, "R5 lines 12 and 3 held off by 10", int'(int_req), 0);
        cur = 16'h1409; idle();
        ack_expect(0, "R5 line 0 preempts upper unit");
        do_eoi();
        chk(int_req == 1'b0, "R6 upper slot still busy", int'(int_req), 0);
        do_eoi();
        ack_expect(12, "R6 freed slot serves 12 before 3");
        do_eoi();
        ack_expect(3, "R6 then line 3");
        do_eoi(); cur = 16'h0; idle();

        // R9: global disable
        step(cur, 0, 0, 0, 1, 0, 16'h0);
        cur = 16'h0080; idle();
        chk(int_req == 1'b0, "R9 disabled blocks request", int'(int_req), 0);
        do_ack();
        chk(vec_valid == 1'b0, "R9 ack ignored while disabled", int'(vec_valid), 0);
        step(cur, 0, 0, 1, 0, 0, 16'h0);
        ack_expect(7, "R9 pending kept across disable");
        do_eoi();
        cur = 16'h00C0; idle();
        chk(int_req == 1'b1, "R9 line 6 requests", int'(int_req), 1);
        step(cur, 0, 0, 1, 1, 0, 16'h0);
        chk(int_req == 1'b0, "R9 clear wins over set", int'(int_req), 0);
        step(cur, 0, 0, 1, 0, 0, 16'h0);
        ack_expect(6, "R9 line 6 after re-enable");
        do_eoi(); cur = 16'h0; idle();

        // R10: mask keeps latched edges
        do_mask(16'h0020);
        cur = 16'h0020; idle();
        chk(int_req == 1'b0, "R10 masked line hidden", int'(int_req), 0);
        do_mask(16'h0000);
        ack_expect(5, "R10 released after unmask");
        do_eoi();
        do_mask(16'h0004);
        cur = 16'h0820; idle();
        ack_expect(11, "R10 mask bit 2 has no effect");
        do_eoi();
        do_mask(16'h0000); cur = 16'h0; idle();

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] flip;
            flip = 16'($urandom) & 16'($urandom) & 16'($urandom);
            cur = cur ^ flip;
            step(cur, ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 20) == 0,
                 ($urandom % 40) == 0, ($urandom % 60) == 0, 16'($urandom) & 16'($urandom));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule